// File: doc/BRIEF.md
# Predicated Bundle Commit Unit

This block is the retirement stage of a three-wide statically scheduled core that replaces branch prediction with predication. Every cycle it may receive one bundle of three operations. Each operation arrives with a predicate index, an optional register result (destination and value), and an optional compare outcome that names two predicate registers. The unit holds the predicate register file and the architectural register file. A slot's effects are applied only when the predicate it names reads true.

Both arms of a conditional are issued side by side, each guarded by one half of a complementary predicate pair. The arm whose predicate is false has its results silently dropped. Nothing is ever flushed or rolled back. A compare's effect on the predicate file becomes visible to the following bundle, not to its siblings in the same bundle. A combinational read port exposes the register file, and the full predicate vector is driven out for use by issue logic.

Top module: `pbc_commit_unit`

## Requirements
- R1: After reset, every predicate register reads false except predicate 0, and every data register reads zero.
- R2: Predicate 0 reads true at all times; a compare naming index 0 as either target leaves it true.
- R3: When `bundle_valid` is high, a slot with `slot_wen` set whose predicate (selected by its 3-bit field in `slot_pidx`, slot s at bits [3s+2:3s]) reads true raises bit s of `commit_mask` in the same cycle, and its value lands in the destination register at the next clock edge.
- R4: A slot whose predicate reads false does not raise its `commit_mask` bit and leaves its destination register unchanged.
- R5: A compare operation whose predicate reads true writes its outcome to the first named predicate and the inverse of the outcome to the second, effective from the next clock edge.
- R6: A compare operation whose predicate reads false leaves every predicate unchanged.
- R7: Every slot of a bundle is gated by the predicate values held before that bundle; a compare in the same bundle does not affect its siblings, and it does affect the next bundle.
- R8: When two or more committing slots of one bundle name the same destination, the higher-numbered slot's value is kept.
- R9: When committing compares of one bundle write the same predicate, the higher-numbered slot wins; within one compare that names the same index twice, the inverse outcome is kept.
- R10: While `bundle_valid` is low, no predicate or register changes and `commit_mask` is zero.
- R11: `rd_data` shows the register selected by `rd_idx` combinationally, reflecting a write from the cycle after its commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bundle_valid | input | 1 | A bundle is present this cycle |
| slot_wen | input | SLOTS | Per slot: operation produces a register result |
| slot_pidx | input | SLOTS*PI_W | Per slot guarding predicate index |
| slot_dst | input | SLOTS*RI_W | Per slot destination register |
| slot_result | input | SLOTS*DATA_W | Per slot result value |
| slot_cmp | input | SLOTS | Per slot: operation is a compare |
| slot_cmp_res | input | SLOTS | Per slot compare outcome |
| slot_cmp_pt | input | SLOTS*PI_W | Per slot predicate receiving the outcome |
| slot_cmp_pf | input | SLOTS*PI_W | Per slot predicate receiving the inverse |
| rd_idx | input | RI_W | Register read select |
| rd_data | output | DATA_W | Selected register value |
| pred_bits | output | NPRED | Current predicate register contents |
| commit_mask | output | SLOTS | Slots committing this cycle |

## Verification
The bench targets a compare and a dependent operation placed in the same bundle; a design that forwarded the fresh predicate would commit the dependent slot one bundle early. It aims several writers at one register and at one predicate, where a reversed priority would keep the lower slot's value. It also covers a compare naming index 0 and a compare naming one index twice, where a design without the hard-wired entry could clear predicate 0 and a design with the wrong order would keep the plain outcome. Finally it drives full bundles with `bundle_valid` low; a design that ignored the valid bit would alter state there.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
   // How the data register file behaves at reset
   typedef enum logic {
      PBC_RST_CLEAR = 1'b0,
      PBC_RST_KEEP  = 1'b1
   } pbc_rst_e;

   function automatic bit pbc_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/pbc_slot_gate.sv
module pbc_slot_gate #(
   parameter int SLOTS = 3,
   parameter int NPRED = 8,
   localparam int PI_W = $clog2(NPRED)
) (
   input  logic                  bundle_valid,
   input  logic [SLOTS-1:0]      slot_wen,
   input  logic [SLOTS-1:0]      slot_cmp,
   input  logic [SLOTS*PI_W-1:0] slot_pidx,
   input  logic [NPRED-1:0]      pred_q,
   output logic [SLOTS-1:0]      commit_mask,
   output logic [SLOTS-1:0]      cmp_fire
);
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [PI_W-1:0] sel;
      logic            guard;
      assign sel   = slot_pidx[s*PI_W +: PI_W];
      assign guard = bundle_valid & pred_q[sel];
      assign commit_mask[s] = guard & slot_wen[s];
      assign cmp_fire[s]    = guard & slot_cmp[s];
   end
endmodule

// File: rtl/pbc_pred_file.sv
module pbc_pred_file #(
   parameter int SLOTS = 3,
   parameter int NPRED = 8,
   localparam int PI_W = $clog2(NPRED)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SLOTS-1:0]      cmp_fire,
   input  logic [SLOTS-1:0]      cmp_res,
   input  logic [SLOTS*PI_W-1:0] cmp_pt,
   input  logic [SLOTS*PI_W-1:0] cmp_pf,
   output logic [NPRED-1:0]      pred_q
);
   // Entry 0 is a constant true guard
   assign pred_q[0] = 1'b1;

   for (genvar p = 1; p < NPRED; p++) begin : g_pred
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else begin
            // ascending slot order: a later slot's write overrides
            for (int s = 0; s < SLOTS; s++) begin
               if (cmp_fire[s]) begin
                  if (cmp_pt[s*PI_W +: PI_W] == PI_W'(p)) bit_q <= cmp_res[s];
                  if (cmp_pf[s*PI_W +: PI_W] == PI_W'(p)) bit_q <= ~cmp_res[s];
               end
            end
         end
      end
      assign pred_q[p] = bit_q;
   end
endmodule

// File: rtl/pbc_reg_file.sv
module pbc_reg_file
   import pbc_pkg::*;
#(
   parameter int       SLOTS     = 3,
   parameter int       NREG      = 16,
   parameter int       DATA_W    = 32,
   parameter pbc_rst_e RST_STYLE = PBC_RST_CLEAR,
   localparam int      RI_W      = $clog2(NREG)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [SLOTS-1:0]        wr_en,
   input  logic [SLOTS*RI_W-1:0]   wr_dst,
   input  logic [SLOTS*DATA_W-1:0] wr_data,
   input  logic [RI_W-1:0]         rd_idx,
   output logic [DATA_W-1:0]       rd_data
);
   logic [DATA_W-1:0] words [NREG];

   for (genvar r = 0; r < NREG; r++) begin : g_word
      logic [DATA_W-1:0] word_q;
      if (RST_STYLE == PBC_RST_CLEAR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '0;
            end else begin
               for (int s = 0; s < SLOTS; s++) begin
                  if (wr_en[s] && wr_dst[s*RI_W +: RI_W] == RI_W'(r))
                     word_q <= wr_data[s*DATA_W +: DATA_W];
               end
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            for (int s = 0; s < SLOTS; s++) begin
               if (wr_en[s] && wr_dst[s*RI_W +: RI_W] == RI_W'(r))
                  word_q <= wr_data[s*DATA_W +: DATA_W];
            end
         end
      end
      assign words[r] = word_q;
   end

   assign rd_data = words[rd_idx];
endmodule

// File: rtl/pbc_commit_unit.sv
module pbc_commit_unit
   import pbc_pkg::*;
#(
   parameter int       SLOTS     = 3,
   parameter int       NPRED     = 8,
   parameter int       NREG      = 16,
   parameter int       DATA_W    = 32,
   parameter pbc_rst_e RST_STYLE = PBC_RST_CLEAR,
   localparam int      PI_W      = $clog2(NPRED),
   localparam int      RI_W      = $clog2(NREG)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bundle_valid,
   input  logic [SLOTS-1:0]        slot_wen,
   input  logic [SLOTS*PI_W-1:0]   slot_pidx,
   input  logic [SLOTS*RI_W-1:0]   slot_dst,
   input  logic [SLOTS*DATA_W-1:0] slot_result,
   input  logic [SLOTS-1:0]        slot_cmp,
   input  logic [SLOTS-1:0]        slot_cmp_res,
   input  logic [SLOTS*PI_W-1:0]   slot_cmp_pt,
   input  logic [SLOTS*PI_W-1:0]   slot_cmp_pf,
   input  logic [RI_W-1:0]         rd_idx,
   output logic [DATA_W-1:0]       rd_data,
   output logic [NPRED-1:0]        pred_bits,
   output logic [SLOTS-1:0]        commit_mask
);
   // elaboration-time parameter checks
   if (SLOTS < 1) begin : g_bad_slots
      $error("pbc_commit_unit: SLOTS must be at least 1");
   end
   if (NPRED < 2 || !pbc_is_pow2(NPRED)) begin : g_bad_npred
      $error("pbc_commit_unit: NPRED must be a power of two >= 2");
   end
   if (NREG < 2 || !pbc_is_pow2(NREG)) begin : g_bad_nreg
      $error("pbc_commit_unit: NREG must be a power of two >= 2");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("pbc_commit_unit: DATA_W must be positive");
   end

   logic [NPRED-1:0] pred_q;
   logic [SLOTS-1:0] cmp_fire;
   logic [SLOTS-1:0] wr_en;

   pbc_slot_gate #(.SLOTS(SLOTS), .NPRED(NPRED)) u_gate (
      .bundle_valid (bundle_valid),
      .slot_wen     (slot_wen),
      .slot_cmp     (slot_cmp),
      .slot_pidx    (slot_pidx),
      .pred_q       (pred_q),
      .commit_mask  (wr_en),
      .cmp_fire     (cmp_fire)
   );

   pbc_pred_file #(.SLOTS(SLOTS), .NPRED(NPRED)) u_pred (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_fire (cmp_fire),
      .cmp_res  (slot_cmp_res),
      .cmp_pt   (slot_cmp_pt),
      .cmp_pf   (slot_cmp_pf),
      .pred_q   (pred_q)
   );

   pbc_reg_file #(
      .SLOTS(SLOTS), .NREG(NREG), .DATA_W(DATA_W), .RST_STYLE(RST_STYLE)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_dst  (slot_dst),
      .wr_data (slot_result),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   assign pred_bits   = pred_q;
   assign commit_mask = wr_en;
endmodule

// File: rtl/pbc_commit_chk.sv
module pbc_commit_chk #(
   parameter int SLOTS  = 3,
   parameter int NPRED  = 8,
   parameter int NREG   = 16,
   parameter int DATA_W = 32,
   localparam int PI_W  = $clog2(NPRED),
   localparam int RI_W  = $clog2(NREG)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bundle_valid,
   input logic [SLOTS-1:0]        slot_wen,
   input logic [SLOTS*PI_W-1:0]   slot_pidx,
   input logic [SLOTS*RI_W-1:0]   slot_dst,
   input logic [SLOTS*DATA_W-1:0] slot_result,
   input logic [SLOTS-1:0]        slot_cmp,
   input logic [SLOTS-1:0]        slot_cmp_res,
   input logic [SLOTS*PI_W-1:0]   slot_cmp_pt,
   input logic [SLOTS*PI_W-1:0]   slot_cmp_pf,
   input logic [RI_W-1:0]         rd_idx,
   input logic [DATA_W-1:0]       rd_data,
   input logic [NPRED-1:0]        pred_bits,
   input logic [SLOTS-1:0]        commit_mask
);
   localparam int T = SLOTS - 1;

   logic [PI_W-1:0]   top_pidx, top_pt, top_pf;
   logic [RI_W-1:0]   top_dst;
   logic [DATA_W-1:0] top_val;
   logic              top_cmp_live;

   assign top_pidx = slot_pidx[T*PI_W +: PI_W];
   assign top_pt   = slot_cmp_pt[T*PI_W +: PI_W];
   assign top_pf   = slot_cmp_pf[T*PI_W +: PI_W];
   assign top_dst  = slot_dst[T*RI_W +: RI_W];
   assign top_val  = slot_result[T*DATA_W +: DATA_W];
   assign top_cmp_live = bundle_valid && slot_cmp[T] && pred_bits[top_pidx]
                         && top_pt != '0 && top_pf != '0 && top_pt != top_pf;

   p_pred0_true_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pred_bits[0]);

   p_reset_preds_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> pred_bits == NPRED'(1));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bundle_valid |=> $stable(pred_bits));

   p_idle_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bundle_valid |-> commit_mask == '0);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      p_false_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (bundle_valid && slot_wen[s] && !pred_bits[slot_pidx[s*PI_W +: PI_W]])
         |-> !commit_mask[s]);
   end

   p_cmp_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      top_cmp_live |=> (pred_bits[$past(top_pt)] == $past(slot_cmp_res[T]))
                    && (pred_bits[$past(top_pf)] == !$past(slot_cmp_res[T])));

   p_top_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_mask[T] && top_dst == rd_idx)
      |=> (rd_idx != $past(rd_idx)) || (rd_data == $past(top_val)));
endmodule

bind pbc_commit_unit pbc_commit_chk #(
   .SLOTS(SLOTS), .NPRED(NPRED), .NREG(NREG), .DATA_W(DATA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bundle_valid (bundle_valid),
   .slot_wen     (slot_wen),
   .slot_pidx    (slot_pidx),
   .slot_dst     (slot_dst),
   .slot_result  (slot_result),
   .slot_cmp     (slot_cmp),
   .slot_cmp_res (slot_cmp_res),
   .slot_cmp_pt  (slot_cmp_pt),
   .slot_cmp_pf  (slot_cmp_pf),
   .rd_idx       (rd_idx),
   .rd_data      (rd_data),
   .pred_bits    (pred_bits),
   .commit_mask  (commit_mask)
);

// File: tb/sim_pbc_commit_unit.sv
module sim_pbc_commit_unit;
   localparam int CLK_PERIOD = 10;
   localparam int SL = 3;
   localparam int NP = 8;
   localparam int NR = 16;
   localparam int DW = 32;
   localparam int PW = 3;
   localparam int RW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // bench-side bundle fields
   logic          b_valid;
   logic          b_wen  [SL];
   logic [PW-1:0] b_pidx [SL];
   logic [RW-1:0] b_dst  [SL];
   logic [DW-1:0] b_res  [SL];
   logic          b_cmp  [SL];
   logic          b_cres [SL];
   logic [PW-1:0] b_pt   [SL];
   logic [PW-1:0] b_pf   [SL];
   logic [RW-1:0] rd;

   logic [SL-1:0]    wen_v, cmp_v, cres_v;
   logic [SL*PW-1:0] pidx_v, pt_v, pf_v;
   logic [SL*RW-1:0] dst_v;
   logic [SL*DW-1:0] res_v;
   logic [DW-1:0]    rd_data;
   logic [NP-1:0]    pred_bits;
   logic [SL-1:0]    commit_mask;

   always_comb begin
      for (int s = 0; s < SL; s++) begin
         wen_v[s]            = b_wen[s];
         cmp_v[s]            = b_cmp[s];
         cres_v[s]           = b_cres[s];
         pidx_v[s*PW +: PW]  = b_pidx[s];
         pt_v[s*PW +: PW]    = b_pt[s];
         pf_v[s*PW +: PW]    = b_pf[s];
         dst_v[s*RW +: RW]   = b_dst[s];
         res_v[s*DW +: DW]   = b_res[s];
      end
   end

   pbc_commit_unit #(.SLOTS(SL), .NPRED(NP), .NREG(NR), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .bundle_valid(b_valid),
      .slot_wen(wen_v), .slot_pidx(pidx_v), .slot_dst(dst_v),
      .slot_result(res_v), .slot_cmp(cmp_v), .slot_cmp_res(cres_v),
      .slot_cmp_pt(pt_v), .slot_cmp_pf(pf_v), .rd_idx(rd),
      .rd_data(rd_data), .pred_bits(pred_bits), .commit_mask(commit_mask)
   );

   // reference state
   logic [DW-1:0] m_reg [NR];
   logic [NP-1:0] m_pred;
   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [SL-1:0] exp_mask();
      logic [SL-1:0] m;
      for (int s = 0; s < SL; s++)
         m[s] = b_valid && b_wen[s] && m_pred[b_pidx[s]];
      return m;
   endfunction

   task automatic model_step();
      logic [SL-1:0] wm;
      logic [NP-1:0] np;
      wm = exp_mask();
      np = m_pred;
      for (int s = 0; s < SL; s++) begin
         if (wm[s]) m_reg[b_dst[s]] = b_res[s];
         if (b_valid && b_cmp[s] && m_pred[b_pidx[s]]) begin
            np[b_pt[s]] = b_cres[s];
            np[b_pf[s]] = ~b_cres[s];
         end
      end
      np[0] = 1'b1;
      m_pred = np;
   endtask

   task automatic clear_bundle();
      b_valid = 1'b0;
      for (int s = 0; s < SL; s++) begin
         b_wen[s] = 0; b_pidx[s] = 0; b_dst[s] = 0; b_res[s] = 0;
         b_cmp[s] = 0; b_cres[s] = 0; b_pt[s] = 0; b_pf[s] = 0;
      end
   endtask

   task automatic set_wr(input int s, input logic [PW-1:0] p,
                         input logic [RW-1:0] d, input logic [DW-1:0] v);
      b_valid = 1'b1; b_wen[s] = 1'b1; b_pidx[s] = p; b_dst[s] = d; b_res[s] = v;
   endtask

   task automatic set_cmp(input int s, input logic [PW-1:0] p, input logic [PW-1:0] t,
                          input logic [PW-1:0] f, input logic r);
      b_valid = 1'b1; b_cmp[s] = 1'b1; b_pidx[s] = p; b_pt[s] = t; b_pf[s] = f; b_cres[s] = r;
   endtask

   // called just after a falling edge with inputs set
   task automatic run_cycle(input string tag);
      #1;
      chk(tag, 64'(commit_mask), 64'(exp_mask()));
      chk(tag, 64'(pred_bits), 64'(m_pred));
      chk(tag, 64'(rd_data), 64'(m_reg[rd]));
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic check_reg(input logic [RW-1:0] idx, input logic [DW-1:0] v, input string tag);
      clear_bundle();
      rd = idx;
      #1;
      chk(tag, 64'(rd_data), 64'(v));
      @(negedge clk);
   endtask

   task automatic check_pred(input logic [NP-1:0] v, input string tag);
      clear_bundle();
      #1;
      chk(tag, 64'(pred_bits), 64'(v));
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      clear_bundle();
      rd = 0;
      for (int r = 0; r < NR; r++) m_reg[r] = '0;
      m_pred = NP'(1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check_pred(8'h01, "R1");
      check_reg(4'd5, 32'h0, "R1");
      check_reg(4'd15, 32'h0, "R1");

      // R2: compare aimed at index 0 cannot clear it
      clear_bundle(); set_cmp(0, 3'd0, 3'd0, 3'd3, 1'b0); run_cycle("R2");
      check_pred(8'b0000_1001, "R2");

      // R5: complementary pair write
      clear_bundle(); set_cmp(1, 3'd0, 3'd1, 3'd2, 1'b1); run_cycle("R5");
      check_pred(8'b0000_1011, "R5");

      // R7: sibling slot sees old predicate, next bundle sees new
      clear_bundle(); set_cmp(0, 3'd0, 3'd4, 3'd5, 1'b1);
      set_wr(2, 3'd4, 4'd7, 32'hAAAA_0001);
      #1; chk("R7", 64'(commit_mask), 64'h0);
      run_cycle("R7");
      check_reg(4'd7, 32'h0, "R7");
      clear_bundle(); set_wr(2, 3'd4, 4'd7, 32'hAAAA_0002);
      #1; chk("R7", 64'(commit_mask), 64'h4);
      run_cycle("R7");
      check_reg(4'd7, 32'hAAAA_0002, "R7");

      // R4: false predicate drops the result
      clear_bundle(); set_wr(0, 3'd2, 4'd7, 32'h5555_5555); run_cycle("R4");
      check_reg(4'd7, 32'hAAAA_0002, "R4");

      // R6: compare under a false predicate does nothing
      clear_bundle(); set_cmp(1, 3'd2, 3'd1, 3'd3, 1'b0); run_cycle("R6");
      check_pred(8'b0001_1011, "R6");

      // R8: same destination, higher slot wins
      clear_bundle();
      set_wr(0, 3'd0, 4'd9, 32'h11); set_wr(1, 3'd0, 4'd9, 32'h22); set_wr(2, 3'd0, 4'd9, 32'h33);
      run_cycle("R8");
      check_reg(4'd9, 32'h33, "R8");
      clear_bundle();
      set_wr(0, 3'd0, 4'd10, 32'h44); set_wr(1, 3'd1, 4'd10, 32'h55); set_wr(2, 3'd2, 4'd10, 32'h66);
      run_cycle("R8");
      check_reg(4'd10, 32'h55, "R8");

      // R9: competing compares, and one compare naming an index twice
      clear_bundle();
      set_cmp(0, 3'd0, 3'd6, 3'd7, 1'b1);
      set_cmp(1, 3'd0, 3'd5, 3'd5, 1'b0);
      set_cmp(2, 3'd0, 3'd7, 3'd6, 1'b1);
      run_cycle("R9");
      check_pred(8'hBB, "R9");

      // R10: full bundle with valid low changes nothing
      clear_bundle();
      for (int s = 0; s < SL; s++) begin
         b_wen[s] = 1; b_dst[s] = 4'd9; b_res[s] = 32'hDEAD; b_cmp[s] = 1;
         b_pt[s] = 3'd1; b_pf[s] = 3'd3; b_cres[s] = 1'b0;
      end
      rd = 4'd9;
      #1; chk("R10", 64'(commit_mask), 64'h0);
      @(negedge clk);
      check_pred(8'hBB, "R10");
      check_reg(4'd9, 32'h33, "R10");

      // R11: read port shows old value before the edge, new value after
      clear_bundle(); set_wr(1, 3'd0, 4'd3, 32'h1234); rd = 4'd3;
      #1; chk("R11", 64'(rd_data), 64'h0);
      @(negedge clk);
      clear_bundle(); rd = 4'd3;
      #1; chk("R11", 64'(rd_data), 64'h1234);
      @(negedge clk);
      m_reg[3] = 32'h1234;

      // R3: constrained random bundles against the reference model
      for (int i = 0; i < 3000; i++) begin
         clear_bundle();
         b_valid = ($urandom % 8) != 0;
         for (int s = 0; s < SL; s++) begin
            b_pidx[s] = (($urandom % 4) == 0) ? 3'd0 : PW'($urandom % NP);
            b_wen[s]  = ($urandom % 3) != 0;
            b_dst[s]  = RW'($urandom % NR);
            b_res[s]  = $urandom;
            b_cmp[s]  = ($urandom % 3) == 0;
            b_cres[s] = $urandom % 2;
            b_pt[s]   = PW'($urandom % NP);
            b_pf[s]   = PW'($urandom % NP);
         end
         rd = RW'($urandom % NR);
         run_cycle("R3");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule